// File: doc/BRIEF.md
# Serial Shift Register with Incremental Ones Tally

This block is a serial-in shift register of parameterised length. Next to it sits a counter that always reports how many of the register's bits are 1. The counter never examines the whole register. On each accepted bit it looks only at the bit entering at the low end and the bit dropping off the high end, then holds, steps up or steps down by one. For long registers this keeps the counting logic to a few gates and one small adder, whatever the length.

Bits arrive on a valid/ready input. A bit is taken on a rising clock edge when `in_valid` and `in_ready` are both high. The block applies back-pressure only while `clear` is high: during that time `in_ready` is low and no bit is accepted. In every other cycle `in_ready` is high, so a source that keeps `in_valid` high can deliver one bit per cycle. The register contents and the tally are plain registered outputs. `clear` is a plain synchronous control pin.

Top module: `ones_tracking_shreg`

## Requirements
- R1: After a synchronous active-low reset, `sr_q` is all zeros and `ones_count` is 0.
- R2: On an accepted bit, `sr_q` becomes `{sr_q[LENGTH-2:0], in_bit}`. The new bit enters bit 0, and the bit leaving is bit LENGTH-1 of the value before the shift.
- R3: On an accepted bit whose entering value equals the leaving value, `ones_count` stays the same.
- R4: On an accepted bit where a 1 enters and a 0 leaves, `ones_count` rises by exactly one.
- R5: On an accepted bit where a 0 enters and a 1 leaves, `ones_count` falls by exactly one.
- R6: While `clear` is high, `in_ready` is low. In the next cycle both `sr_q` and `ones_count` are zero, even if `in_valid` was high. Clear has priority over an offered bit.
- R7: In a cycle with no accepted bit and no clear, neither `sr_q` nor `ones_count` changes.
- R8: `ones_count` is `$clog2(LENGTH)+1` bits wide. It always equals the number of 1 bits in `sr_q`, so it never exceeds LENGTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Synchronous clear of register and tally |
| in_valid | input | 1 | Source offers `in_bit` |
| in_bit | input | 1 | Serial data bit |
| in_ready | output | 1 | Block can accept a bit (low only during clear) |
| sr_q | output | LENGTH | Register contents, bit 0 newest |
| ones_count | output | $clog2(LENGTH)+1 | Number of 1 bits held in `sr_q` |

## Verification
The tally is built by accumulating ±1 steps, so a wrong step does not fade away. A mistaken increment or decrement, a missed clear or a shift taken without a handshake leaves `ones_count` different from the popcount of `sr_q`. The error shows at the ports in the cycle after the faulty edge and stays until a clear or reset. Comparing the outputs each cycle against a reference model therefore catches such a fault one cycle after it happens. Long runs of ones and of zeros drive the tally to LENGTH and to 0, which tests the boundary steps.

// File: rtl/osr_pkg.sv
package osr_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'b00,
    STEP_UP   = 2'b01,
    STEP_DOWN = 2'b10
  } step_e;

  // Net change of the tally when one bit enters and one leaves.
  function automatic step_e classify(input logic entering, input logic leaving);
    if (entering == leaving) return STEP_HOLD;
    else if (entering)       return STEP_UP;
    else                     return STEP_DOWN;
  endfunction

endpackage

// File: rtl/osr_bit_chain.sv
module osr_bit_chain #(
  parameter int LENGTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              advance,
  input  logic              din,
  output logic [LENGTH-1:0] q,
  output logic              tail
);

  for (genvar i = 0; i < LENGTH; i++) begin : g_stage
    logic bit_r;
    logic bit_in;

    if (i == 0) begin : g_head
      assign bit_in = din;
    end else begin : g_body
      assign bit_in = q[i-1];
    end

    always_ff @(posedge clk) begin
      if (!rst_n || clear) bit_r <= 1'b0;
      else if (advance)    bit_r <= bit_in;
    end

    assign q[i] = bit_r;
  end

  assign tail = q[LENGTH-1];

endmodule

// File: rtl/osr_step_decode.sv
module osr_step_decode
  import osr_pkg::*;
(
  input  logic  advance,
  input  logic  entering,
  input  logic  leaving,
  output step_e step
);

  always_comb begin
    if (advance) step = classify(entering, leaving);
    else         step = STEP_HOLD;
  end

endmodule

// File: rtl/osr_tally.sv
module osr_tally
  import osr_pkg::*;
#(
  parameter int LENGTH = 16,
  localparam int CNT_W = $clog2(LENGTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  step_e            step,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] count_r;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      count_r <= '0;
    end else begin
      unique case (step)
        STEP_UP:   count_r <= count_r + 1'b1;
        STEP_DOWN: count_r <= count_r - 1'b1;
        default:   count_r <= count_r;
      endcase
    end
  end

  assign count = count_r;

endmodule

// File: rtl/ones_tracking_shreg.sv
module ones_tracking_shreg
  import osr_pkg::*;
#(
  parameter int LENGTH = 16,
  localparam int CNT_W = $clog2(LENGTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              in_valid,
  input  logic              in_bit,
  output logic              in_ready,
  output logic [LENGTH-1:0] sr_q,
  output logic [CNT_W-1:0]  ones_count
);

  logic  accept;
  logic  leaving_bit;
  step_e step;

  assign in_ready = ~clear;
  assign accept   = in_valid & in_ready;

  osr_bit_chain #(.LENGTH(LENGTH)) u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear),
    .advance (accept),
    .din     (in_bit),
    .q       (sr_q),
    .tail    (leaving_bit)
  );

  osr_step_decode u_decode (
    .advance  (accept),
    .entering (in_bit),
    .leaving  (leaving_bit),
    .step     (step)
  );

  osr_tally #(.LENGTH(LENGTH)) u_tally (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear),
    .step  (step),
    .count (ones_count)
  );

endmodule

// File: rtl/osr_checker.sv
module osr_checker #(
  parameter int LENGTH = 16,
  localparam int CNT_W = $clog2(LENGTH) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clear,
  input logic              in_valid,
  input logic              in_bit,
  input logic              in_ready,
  input logic [LENGTH-1:0] sr_q,
  input logic [CNT_W-1:0]  ones_count
);

  logic take;
  assign take = in_valid && in_ready;

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (sr_q == '0) && (ones_count == '0));

  assert_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> sr_q == {$past(sr_q[LENGTH-2:0]), $past(in_bit)});

  assert_hold_equal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (in_bit == sr_q[LENGTH-1])) |=> $stable(ones_count));

  assert_step_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_bit && !sr_q[LENGTH-1]) |=> ones_count == $past(ones_count) + 1'b1);

  assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_bit && sr_q[LENGTH-1]) |=> ones_count == $past(ones_count) - 1'b1);

  assert_clear_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clear |-> !in_ready);

  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (sr_q == '0) && (ones_count == '0));

  assert_idle_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !clear) |=> $stable(sr_q) && $stable(ones_count));

  assert_tally_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ones_count) == $countones(sr_q));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ones_count) <= LENGTH);

endmodule

bind ones_tracking_shreg osr_checker #(.LENGTH(LENGTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clear      (clear),
  .in_valid   (in_valid),
  .in_bit     (in_bit),
  .in_ready   (in_ready),
  .sr_q       (sr_q),
  .ones_count (ones_count)
);

// File: tb/sim_ones_tracking_shreg.sv
module sim_ones_tracking_shreg;

  localparam int L  = 16;
  localparam int CW = $clog2(L) + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clear = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_bit = 1'b0;
  logic          in_ready;
  logic [L-1:0]  sr_q;
  logic [CW-1:0] ones_count;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    logic [L-1:0] sr;
    int           cnt;
    string        tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t cur;
  logic [L-1:0] model_sr = '0;

  always #5 clk = ~clk;

  ones_tracking_shreg #(.LENGTH(L)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear),
    .in_valid   (in_valid),
    .in_bit     (in_bit),
    .in_ready   (in_ready),
    .sr_q       (sr_q),
    .ones_count (ones_count)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected result.
  task automatic drive(input logic c, input logic v, input logic b);
    exp_t e;
    logic leaving;
    @(negedge clk);
    clear = c; in_valid = v; in_bit = b;
    #1;
    check(in_ready == !c, "R6", "in_ready", in_ready, !c);
    leaving = model_sr[L-1];
    if (c) begin
      model_sr = '0; e.tag = "R6";
    end else if (v) begin
      model_sr = {model_sr[L-2:0], b};
      if (b == leaving) e.tag = "R3";
      else if (b)       e.tag = "R4";
      else              e.tag = "R5";
    end else begin
      e.tag = "R7";
    end
    e.sr  = model_sr;
    e.cnt = $countones(model_sr);
    exp_q.push_back(e);
  endtask

  // Monitor: compares design outputs one step after each edge.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() != 0) begin
      cur = exp_q.pop_front();
      check(sr_q == cur.sr, (cur.tag == "R6" || cur.tag == "R7") ? cur.tag : "R2",
            "sr_q", sr_q, cur.sr);
      check(int'(ones_count) == cur.cnt, cur.tag, "ones_count", ones_count, cur.cnt);
      check(int'(ones_count) == $countones(sr_q) && int'(ones_count) <= L, "R8",
            "count vs popcount", ones_count, $countones(sr_q));
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(sr_q == '0, "R1", "sr_q after reset", sr_q, 0);
    check(ones_count == '0, "R1", "count after reset", ones_count, 0);
    rst_n = 1'b1;

    // Fill with ones: tally climbs to L, then holds as ones replace ones.
    for (int i = 0; i < L + 4; i++) drive(1'b0, 1'b1, 1'b1);
    // Idle with a changing data bit: nothing moves.
    for (int i = 0; i < 4; i++) drive(1'b0, 1'b0, i[0]);
    // Drain with zeros down to 0 and beyond.
    for (int i = 0; i < L + 3; i++) drive(1'b0, 1'b1, 1'b0);
    // Alternating pattern.
    for (int i = 0; i < 2 * L; i++) drive(1'b0, 1'b1, i[0]);
    // Clear while a bit is offered.
    drive(1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 5; i++) drive(1'b0, 1'b1, 1'b1);
    drive(1'b1, 1'b0, 1'b0);
    // Random traffic.
    for (int i = 0; i < 3000; i++) begin
      logic c, v, b;
      c = ($urandom_range(0, 39) == 0);
      v = ($urandom_range(0, 3) != 0);
      b = ($urandom_range(0, 2) != 0);
      drive(c, v, b);
    end
    drive(1'b0, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    #2;
    check(exp_q.size() == 0, "R2", "scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule